// File: doc/BRIEF.md
# Conversion Result Output Bus Controller

This block keeps the most recent corrected conversion result (a data word plus an overflow flag) and presents it on a parallel pin bus that can be released. Every data pin and the overflow pin has its own enable bit, so an enable of 0 stands for high impedance at the pad. Three active-low control inputs set what the bus shows. A chip select and an output enable together decide whether the bus is driven. A byte select chooses between the full word and a narrow form in which the low part of the word moves onto the upper pins. These controls act combinationally on the pins and do not depend on whether a conversion is running.

A new result arrives from the conversion sequencer as a one-cycle valid transfer. The ready output is held high, so the sequencer never sees back-pressure, and a result offered in any cycle is taken at the next clock edge. The interrupt request output shows that a conversion is in progress. It is registered from the sequencer's busy flag and from the result transfer, which means the new result is in the register one cycle before the interrupt request falls. The interrupt request has no enable and is always driven.

Top module: `rbus_out_ctrl`

## Requirements
- R1: After reset the stored word is zero, the stored overflow flag is 0 and irq is 0.
- R2: The bus is driven only while cs_n and oe_n are both 0. If either one is 1, every bit of dq_en is 0 and ovf_en is 0 in the same cycle.
- R3: With the bus driven and wsel_n = 0, dq_en is all ones, ovf_en = 1, dq equals the stored word and ovf equals the stored overflow flag.
- R4: With the bus driven and wsel_n = 1, pins dq[11:8] carry stored bits [3:0], pins dq[7:4] carry 0, dq_en[11:4] are 1, and both dq_en[3:0] and ovf_en are 0.
- R5: When res_valid is 1 at a rising edge, the stored word and flag take res_data and res_ovf. When res_valid is 0, they keep their value. res_ready is always 1.
- R6: irq is 1 in the cycle after any cycle in which conv_busy or res_valid is 1, and 0 otherwise. A result that ends a conversion is therefore stored one cycle before irq falls.
- R7: irq is driven regardless of cs_n, oe_n and wsel_n, and those inputs do not change it.
- R8: The bus enables and the byte mapping respond to cs_n, oe_n and wsel_n in the same cycle, including while conv_busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | A new result is offered this cycle |
| res_ready | output | 1 | Always 1: results are never refused |
| res_data | input | 12 | Corrected result word |
| res_ovf | input | 1 | Overflow flag of the result |
| conv_busy | input | 1 | The sequencer is in a conversion (hold phase) |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| wsel_n | input | 1 | Low: full word; high: low part on the upper pins |
| dq | output | 12 | Data pin values |
| dq_en | output | 12 | Per-pin drive enables (0 = high impedance) |
| ovf | output | 1 | Overflow pin value |
| ovf_en | output | 1 | Overflow pin drive enable |
| irq | output | 1 | Conversion-in-progress flag, always driven |

## Verification
The bench builds the block with its default parameters: a 12-bit word, 8 upper pins and a 4-bit low part. The byte form then shifts a 4-bit field across pins and leaves 4 pins undriven, so every pin class appears, meaning upper shared pins, zero-padding pins and released low pins. Random control and result traffic covers all eight combinations of the three select lines while results load and conversions run. Directed cases set the word to all ones and to alternating bit patterns, so a misplaced nibble or a wrong padding bit shows up at once.

// File: rtl/rbus_out_pkg.sv
package rbus_out_pkg;
  localparam int WORD_W = 12;

  typedef struct packed {
    logic              ovf;
    logic [WORD_W-1:0] word;
  } result_t;
endpackage

// File: rtl/rbus_result_reg.sv
module rbus_result_reg #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_ovf,
  output logic [WORD_W-1:0] held_word,
  output logic              held_ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_word <= '0;
      held_ovf  <= 1'b0;
    end else if (load) begin
      held_word <= in_word;
      held_ovf  <= in_ovf;
    end
  end

  assert_load_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (held_word == $past(in_word)) && (held_ovf == $past(in_ovf)));
  assert_hold_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held_word) && $stable(held_ovf));
endmodule

// File: rtl/rbus_irq_gen.sv
module rbus_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic taken,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= busy | taken;
  end

  assert_irq_after_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> irq);
  assert_irq_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !taken) |=> !irq);
endmodule

// File: rtl/rbus_pin_mux.sv
module rbus_pin_mux #(
  parameter int WORD_W = 12,
  parameter int HI_W   = 8
) (
  input  logic [WORD_W-1:0] held_word,
  input  logic              held_ovf,
  input  logic              sel_n,
  input  logic              out_n,
  input  logic              wide_n,
  output logic [WORD_W-1:0] pin_val,
  output logic [WORD_W-1:0] pin_en,
  output logic              ovf_val,
  output logic              ovf_drv
);
  localparam int LO_W  = WORD_W - HI_W;
  localparam int PAD_W = HI_W - LO_W;

  logic drive;
  logic [WORD_W-1:0] narrow_val;
  logic [WORD_W-1:0] narrow_en;

  assign drive = !sel_n && !out_n;

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_pin
      if (i >= WORD_W - LO_W) begin : g_field
        assign narrow_val[i] = held_word[i - (WORD_W - LO_W)];
        assign narrow_en[i]  = 1'b1;
      end else if (i >= LO_W) begin : g_pad
        assign narrow_val[i] = 1'b0;
        assign narrow_en[i]  = 1'b1;
      end else begin : g_off
        assign narrow_val[i] = 1'b0;
        assign narrow_en[i]  = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    pin_val = '0;
    pin_en  = '0;
    ovf_val = 1'b0;
    ovf_drv = 1'b0;
    if (drive) begin
      if (!wide_n) begin
        pin_val = held_word;
        pin_en  = '1;
        ovf_val = held_ovf;
        ovf_drv = 1'b1;
      end else begin
        pin_val = narrow_val;
        pin_en  = narrow_en;
      end
    end
  end

  always_comb begin
    if (sel_n || out_n)
      assert_released_R2: assert (pin_en == '0 && !ovf_drv);
    if (drive && wide_n)
      assert_narrow_no_low_R4: assert (pin_en[LO_W-1:0] == '0 && !ovf_drv);
  end

  if (PAD_W < 0) begin : g_bad_width
    initial $error("low part wider than upper pin group");
  end
endmodule

// File: rtl/rbus_out_ctrl.sv
module rbus_out_ctrl
  import rbus_out_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [WORD_W-1:0] res_data,
  input  logic              res_ovf,
  input  logic              conv_busy,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              wsel_n,
  output logic [WORD_W-1:0] dq,
  output logic [WORD_W-1:0] dq_en,
  output logic              ovf,
  output logic              ovf_en,
  output logic              irq
);
  result_t held;
  logic    take;

  assign res_ready = 1'b1;
  assign take      = res_valid & res_ready;

  rbus_result_reg #(.WORD_W(WORD_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .load(take),
    .in_word(res_data), .in_ovf(res_ovf),
    .held_word(held.word), .held_ovf(held.ovf)
  );

  rbus_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .busy(conv_busy), .taken(take), .irq(irq)
  );

  rbus_pin_mux #(.WORD_W(WORD_W), .HI_W(HI_W)) u_mux (
    .held_word(held.word), .held_ovf(held.ovf),
    .sel_n(cs_n), .out_n(oe_n), .wide_n(wsel_n),
    .pin_val(dq), .pin_en(dq_en), .ovf_val(ovf), .ovf_drv(ovf_en)
  );

  assert_ready_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready);
  assert_full_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !oe_n && !wsel_n) |-> (dq == held.word) && ovf_en && (ovf == held.ovf));
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (held == '0) && !irq);
endmodule

// File: tb/rbus_out_ctrl_test.sv
module rbus_out_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0, res_ovf = 1'b0, conv_busy = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, wsel_n = 1'b0;
  logic [11:0] res_data = '0;
  logic res_ready, ovf, ovf_en, irq;
  logic [11:0] dq, dq_en;

  int total = 0, bad = 0;
  logic [11:0] m_word = '0;
  logic m_ovf = 1'b0, m_irq = 1'b0;

  always #10 clk = ~clk;

  rbus_out_ctrl uut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_ovf(res_ovf), .conv_busy(conv_busy),
    .cs_n(cs_n), .oe_n(oe_n), .wsel_n(wsel_n),
    .dq(dq), .dq_en(dq_en), .ovf(ovf), .ovf_en(ovf_en), .irq(irq)
  );

  function automatic logic [12:0] exp_en(logic c, logic o, logic w);
    if (c || o) return 13'h0000;
    if (!w)     return 13'h1FFF;
    return {1'b0, 8'hFF, 4'h0};
  endfunction

  function automatic logic [12:0] exp_val(logic c, logic o, logic w,
                                          logic [11:0] wd, logic f);
    if (c || o) return 13'h0000;
    if (!w)     return {f, wd};
    return {1'b0, wd[3:0], 8'h00};
  endfunction

  task automatic check(string req, logic [12:0] act, logic [12:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_pins(string req);
    logic [12:0] en = exp_en(cs_n, oe_n, wsel_n);
    check({req, " en"}, {ovf_en, dq_en}, en);
    check({req, " val"}, {ovf, dq} & en,
          exp_val(cs_n, oe_n, wsel_n, m_word, m_ovf) & en);
  endtask

  task automatic step();
    @(posedge clk);
    if (res_valid) begin m_word = res_data; m_ovf = res_ovf; end
    m_irq = conv_busy | res_valid;
    #2;
    check("R6 irq", {12'b0, irq}, {12'b0, m_irq});
  endtask

  initial begin
    #200000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b0; wsel_n = 1'b0; #1;
    check("R1 reset word", {ovf, dq}, 13'h0000);
    check("R1 reset irq", {12'b0, irq}, 13'h0000);
    @(negedge clk) rst_n = 1'b1;

    // R5: load all ones, R3: full word
    @(negedge clk) begin res_valid = 1; res_data = 12'hFFF; res_ovf = 1; conv_busy = 1; end
    step();
    @(negedge clk) begin res_valid = 0; conv_busy = 0; end #1;
    check_pins("R3 all ones");
    check("R5 ready", {12'b0, res_ready}, 13'h0001);
    check("R6 irq high before fall", {12'b0, irq}, 13'h0001);
    step();
    // R4 narrow with alternating bits
    @(negedge clk) begin res_valid = 1; res_data = 12'hA5C; res_ovf = 0; end
    step();
    @(negedge clk) begin res_valid = 0; wsel_n = 1; end #1;
    check_pins("R4 narrow A5C");
    check("R4 exact pins", {ovf_en, dq_en, dq}, {1'b0, 12'hFF0, 12'hC00});
    // R2: release on either select
    @(negedge clk) oe_n = 1; #1;
    check_pins("R2 oe high");
    @(negedge clk) begin oe_n = 0; cs_n = 1; end #1;
    check_pins("R2 cs high");
    // R7: irq follows busy with bus released; R8 bus during busy
    @(negedge clk) conv_busy = 1;
    step();
    @(negedge clk) begin cs_n = 0; wsel_n = 0; end #1;
    check_pins("R8 driven while busy");
    check("R7 irq while selects move", {12'b0, irq}, 13'h0001);
    @(negedge clk) begin conv_busy = 0; cs_n = 1; end
    step();

    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      res_valid = ($urandom % 4) == 0;
      res_data  = 12'($urandom);
      res_ovf   = 1'($urandom);
      conv_busy = ($urandom % 3) == 0;
      cs_n      = 1'($urandom);
      oe_n      = 1'($urandom);
      wsel_n    = 1'($urandom);
      #1;
      check_pins("R2/R3/R4/R8 random");
      check("R5 ready", {12'b0, res_ready}, 13'h0001);
      step();
      #3;
      cs_n = 1'($urandom); oe_n = 1'($urandom); wsel_n = 1'($urandom);
      #1;
      check("R7 irq stable", {12'b0, irq}, {12'b0, m_irq});
      check_pins("R8 mid-cycle change");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule